// File: doc/BRIEF.md
# Addressed Two-Wire Bus Status/Control Node

This block is the node end of a multidrop, two-wire addressed bus. Line recovery sits outside it and delivers the bus as a stream of decoded bits. Each bit arrives as a one-cycle strobe with a data value. The block finds word alignment from a run of ones that ends in a zero. From then on it cuts the stream into back-to-back 10-bit words. A word addressed to this node either asks for the node's two status inputs or sets its two control outputs.

To answer a status request, the node takes over the last three bit slots of the word. It raises a pull-down enable in each slot that must carry a zero and leaves the line alone for a one. A sticky fault flag records any parity error seen in a word to this node. While the flag is set, control updates are refused and every status reply reads as all ones. Only a status request with correct address parity clears the flag.

Top module: `serial_status_node`

## Requirements
- R1: After synchronous active-low reset, `ctl_out` is 0, `pull_dn` is 0 and the fault flag is clear. The node decodes no word until it has seen a sync, so a well-formed write sent before any sync leaves `ctl_out` at 0.
- R2: A sync is a run of at least 8 ones ended by a 0, and the next bit starts a word. A run of only 7 ones ended by a 0 is not a sync. Stray bits ahead of a valid sync do not affect the word that follows the sync.
- R3: A word is 10 bits, sent in this order: five address bits (least significant first), address parity, request bit (0 = read, 1 = write), D0, D1, data parity. Words follow each other without a new sync.
- R4: A read to this node with even address parity and no fault produces a reply. The three reply slots carry D0 = `stat_in[0]`, D1 = `stat_in[1]` and P = D0 xor D1, in that order. `pull_dn` is high during a slot exactly when that slot's bit is 0. It changes only in the cycle after a strobe, and it is 0 once the word ends.
- R5: A word whose address differs from `node_addr` never raises `pull_dn` and never changes `ctl_out`. A parity error in such a word does not set the fault flag.
- R6: A write to this node changes `ctl_out` to {D1, D0} in the cycle after the final strobe. This happens only when the first six bits hold an even number of ones, D0, D1 and the parity bit together hold an even number of ones, and no fault is pending.
- R7: Odd address parity, or odd data parity on a write, in a word to this node sets the fault flag, and `ctl_out` keeps its value.
- R8: While the fault flag is set, or when the read word itself has odd address parity, a read reply is three ones, so `pull_dn` stays low.
- R9: While the fault flag is set, a write with correct parities leaves `ctl_out` unchanged.
- R10: A read to this node with even address parity clears the fault flag at the end of the word, after the all-ones reply. The next read returns live status. A read with odd address parity leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe marking a decoded line bit |
| bit_val | input | 1 | Value of the strobed line bit |
| node_addr | input | 5 | Static address of this node |
| stat_in | input | 2 | Status inputs reported by a read |
| ctl_out | output | 2 | Control output latches set by a write |
| pull_dn | output | 1 | Line pull-down enable during reply slots |

## Verification
The bench sends a run of exactly seven ones as a near-miss sync. A detector that counted one short would lock onto it and apply the write that follows. Each reply is checked slot by slot with the bench acting as the wired line. Two faults are caught this way: a swapped D0/D1 order, and a reply parity that is odd instead of even. The fault sequence is tested in full: a bad-parity read, then a refused write, then a clearing read that still answers all ones, then live status. A design that clears the flag on the wrong word, clears it too early, or lets a write through would break one of these steps. Mismatched addresses with bad parity check that the flag cannot be set by another node's traffic.

// File: rtl/node_pkg.sv
// Package: shared constants for the addressed bus node.
// Assumes the two-bit data field is fixed by the word format.
package node_pkg;
    localparam int DATA_W  = 2;   // data bits per word
    localparam int RPLY_W  = 3;   // reply slots: D0, D1, parity
    localparam int TAIL_W  = 5;   // parity, request, D0, D1, data parity

    // Request bit encoding
    typedef enum logic {
        REQ_READ  = 1'b0,
        REQ_WRITE = 1'b1
    } req_e;
endpackage

// File: rtl/run_sync_det.sv
// Module: run_sync_det
// Counts consecutive one bits and flags a sync when a zero ends a run of
// at least RUN_MIN ones. The flag is combinational on the strobe cycle.
// Assumes bit_stb is a single-cycle pulse per line bit.
module run_sync_det #(
    parameter int RUN_MIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic bit_val,
    output logic sync_hit
);
    localparam int CNT_W = $clog2(RUN_MIN + 1);

    logic [CNT_W-1:0] run_q;

    // Saturating count of consecutive ones, cleared by a zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (bit_stb) begin
            if (!bit_val)
                run_q <= '0;
            else if (run_q != CNT_W'(RUN_MIN))
                run_q <= run_q + 1'b1;
        end
    end

    // Sync marker: a zero strobed after a long enough run
    always_comb begin
        sync_hit = bit_stb && !bit_val && (run_q >= CNT_W'(RUN_MIN));
    end
endmodule

// File: rtl/word_framer.sv
// Module: word_framer
// Holds word alignment and collects bits of the current word.
// A sync restarts framing at slot 0; words then run back to back.
// Assumes sync_hit comes from the same strobe as bit_val.
module word_framer #(
    parameter int WORD_LEN = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bit_stb,
    input  logic                        bit_val,
    input  logic                        sync_hit,
    output logic                        locked,
    output logic                        cap,
    output logic [$clog2(WORD_LEN)-1:0] slot,
    output logic [WORD_LEN-1:0]         field
);
    localparam int IDX_W = $clog2(WORD_LEN);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_LEN - 1);

    // A framed bit is any strobe while aligned that is not a sync marker
    always_comb begin
        cap = bit_stb && locked && !sync_hit;
    end

    // Alignment, slot counter and bit capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            slot   <= '0;
            field  <= '0;
        end else if (sync_hit) begin
            locked <= 1'b1;
            slot   <= '0;
        end else if (cap) begin
            field[slot] <= bit_val;
            slot        <= (slot == LAST) ? '0 : slot + 1'b1;
        end
    end
endmodule

// File: rtl/node_ctrl.sv
// Module: node_ctrl
// Decodes framed words: address match, parity checks, fault flag,
// output latch update and reply generation onto the pull-down enable.
// Assumes the field register already holds earlier bits of the word
// when cap strobes a later slot.
module node_ctrl #(
    parameter int ADDR_W = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cap,
    input  logic                              sync_hit,
    input  logic                              bit_val,
    input  logic [$clog2(ADDR_W+5)-1:0]       slot,
    input  logic [ADDR_W+4:0]                 field,
    input  logic [ADDR_W-1:0]                 node_addr,
    input  logic [node_pkg::DATA_W-1:0]       stat_in,
    output logic [node_pkg::DATA_W-1:0]       ctl_out,
    output logic                              pull_dn,
    output logic                              fault
);
    import node_pkg::*;

    localparam int WORD_LEN = ADDR_W + TAIL_W;
    localparam int IDX_W    = $clog2(WORD_LEN);
    localparam int APAR_POS = ADDR_W;
    localparam int REQ_POS  = ADDR_W + 1;
    localparam int D0_POS   = ADDR_W + 2;
    localparam int D1_POS   = ADDR_W + 3;
    localparam int LAST_POS = WORD_LEN - 1;

    logic              addr_hit;
    logic              apar_ok;
    logic              dpar_ok;
    logic              is_write;
    logic [RPLY_W-1:0] rsp_bits;
    logic              rsp_on;
    logic [IDX_W-1:0]  rel;

    // Field decode for the word in progress
    always_comb begin
        addr_hit = (field[ADDR_W-1:0] == node_addr);
        apar_ok  = !(^field[APAR_POS:0]);
        dpar_ok  = !(field[D0_POS] ^ field[D1_POS] ^ bit_val);
        is_write = (field[REQ_POS] == REQ_WRITE);
    end

    // Reply state, fault flag and output latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_on   <= 1'b0;
            rsp_bits <= '1;
            fault    <= 1'b0;
            ctl_out  <= '0;
        end else if (sync_hit) begin
            rsp_on <= 1'b0;
        end else if (cap) begin
            if (slot == IDX_W'(REQ_POS) && addr_hit) begin
                if (!apar_ok)
                    fault <= 1'b1;
                if (bit_val == REQ_READ) begin
                    rsp_on <= 1'b1;
                    if (fault || !apar_ok)
                        rsp_bits <= '1;
                    else
                        rsp_bits <= {stat_in[0] ^ stat_in[1], stat_in[1], stat_in[0]};
                end
            end
            if (slot == IDX_W'(LAST_POS)) begin
                rsp_on <= 1'b0;
                if (addr_hit && apar_ok) begin
                    if (!is_write)
                        fault <= 1'b0;
                    else if (!fault) begin
                        if (dpar_ok)
                            ctl_out <= {field[D1_POS], field[D0_POS]};
                        else
                            fault <= 1'b1;
                    end
                end
            end
        end
    end

    // Pull the line low in a reply slot that carries a zero
    always_comb begin
        rel     = slot - IDX_W'(D0_POS);
        pull_dn = 1'b0;
        if (rsp_on && rel < IDX_W'(RPLY_W))
            pull_dn = !rsp_bits[rel[1:0]];
    end
endmodule

// File: rtl/serial_status_node.sv
// Module: serial_status_node
// Top of the bus node: sync detector, word framer and word controller.
// Assumes bit strobes are single cycles with at least one idle cycle
// between them and node_addr is static.
module serial_status_node #(
    parameter int ADDR_W  = 5,
    parameter int RUN_MIN = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bit_stb,
    input  logic                        bit_val,
    input  logic [ADDR_W-1:0]           node_addr,
    input  logic [node_pkg::DATA_W-1:0] stat_in,
    output logic [node_pkg::DATA_W-1:0] ctl_out,
    output logic                        pull_dn
);
    localparam int WORD_LEN = ADDR_W + node_pkg::TAIL_W;
    localparam int IDX_W    = $clog2(WORD_LEN);

    logic                sync_hit;
    logic                locked;
    logic                cap;
    logic [IDX_W-1:0]    slot;
    logic [WORD_LEN-1:0] field;
    logic                fault_q;

    run_sync_det #(.RUN_MIN(RUN_MIN)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .sync_hit (sync_hit)
    );

    word_framer #(.WORD_LEN(WORD_LEN)) i_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .sync_hit (sync_hit),
        .locked   (locked),
        .cap      (cap),
        .slot     (slot),
        .field    (field)
    );

    node_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (cap),
        .sync_hit  (sync_hit),
        .bit_val   (bit_val),
        .slot      (slot),
        .field     (field),
        .node_addr (node_addr),
        .stat_in   (stat_in),
        .ctl_out   (ctl_out),
        .pull_dn   (pull_dn),
        .fault     (fault_q)
    );
endmodule

// File: rtl/serial_status_node_chk.sv
// Module: serial_status_node_chk
// Temporal checks on the node, attached to every instance by bind.
module serial_status_node_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_stb,
    input logic [1:0] ctl_out,
    input logic       pull_dn,
    input logic       fault,
    input logic       locked
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctl_out == 2'b00 && !fault && !locked && !pull_dn));

    // R6
    ctl_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_out) |-> $past(bit_stb));

    // R9
    ctl_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_out) |-> !$past(fault));

    // R8
    fault_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !pull_dn);

    // R4
    pull_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_dn |-> locked);

    // R4
    pull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pull_dn) |-> $past(bit_stb));

    // R10
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> $past(bit_stb));
endmodule

bind serial_status_node serial_status_node_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_stb (bit_stb),
    .ctl_out (ctl_out),
    .pull_dn (pull_dn),
    .fault   (fault_q),
    .locked  (locked)
);

// File: tb/test_serial_status_node.sv
// Directed bench for serial_status_node: one task per scenario.
module test_serial_status_node;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0;
    logic       bit_val = 1'b1;
    logic [4:0] node_addr = 5'd24;
    logic [1:0] stat_in = 2'b00;
    logic [1:0] ctl_out;
    logic       pull_dn;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    serial_status_node i_serial_status_node (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .node_addr (node_addr),
        .stat_in   (stat_in),
        .ctl_out   (ctl_out),
        .pull_dn   (pull_dn)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One strobed bit driven by the controller
    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_val = b;
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        bit_val = 1'b1;
        @(negedge clk);
    endtask

    // One reply slot: the line carries whatever the node leaves on it
    task automatic reply_slot(output logic seen);
        @(negedge clk);
        seen    = !pull_dn;
        bit_val = seen;
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        bit_val = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_sync(input int ones);
        send_bit(1'b0);
        for (int i = 0; i < ones; i++) send_bit(1'b1);
        send_bit(1'b0);
    endtask

    // Full word; reply holds the three line values seen in a read
    task automatic send_word(input logic [4:0] a, input bit bad_ap, input bit wr,
                             input logic [1:0] d, input bit bad_dp,
                             output logic [2:0] reply);
        logic s;
        for (int i = 0; i < 5; i++) send_bit(a[i]);
        send_bit((^a) ^ bad_ap);
        send_bit(wr);
        reply = 3'b111;
        if (wr) begin
            send_bit(d[0]);
            send_bit(d[1]);
            send_bit(d[0] ^ d[1] ^ bad_dp);
        end else begin
            for (int k = 0; k < 3; k++) begin
                reply_slot(s);
                reply[k] = s;
            end
        end
    endtask

    function automatic logic [2:0] live_reply(input logic [1:0] s);
        return {s[0] ^ s[1], s[1], s[0]};
    endfunction

    task automatic t_reset;
        logic [2:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ctl_out after reset", ctl_out, 0);
        chk("R1 pull_dn after reset", pull_dn, 0);
        send_word(5'd24, 0, 1, 2'b11, 0, r);
        @(negedge clk);
        chk("R1 write before sync ignored", ctl_out, 0);
    endtask

    task automatic t_sync;
        logic [2:0] r;
        send_sync(7);
        send_word(5'd24, 0, 1, 2'b01, 0, r);
        @(negedge clk);
        chk("R2 seven ones not a sync", ctl_out, 0);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_sync(9);
        send_word(5'd24, 0, 1, 2'b11, 0, r);
        @(negedge clk);
        chk("R2 R6 write after sync", ctl_out, 3);
        send_word(5'd24, 0, 1, 2'b10, 0, r);
        @(negedge clk);
        chk("R3 back-to-back write", ctl_out, 2);
    endtask

    task automatic t_read;
        logic [2:0] r;
        for (int s = 0; s < 4; s++) begin
            stat_in = 2'(s);
            send_word(5'd24, 0, 0, 2'b00, 0, r);
            chk("R4 reply slots", r, live_reply(2'(s)));
            @(negedge clk);
            chk("R4 pull_dn low after word", pull_dn, 0);
        end
        chk("R4 read keeps ctl_out", ctl_out, 2);
    endtask

    task automatic t_mismatch;
        logic [2:0] r;
        stat_in = 2'b00;
        send_word(5'd23, 0, 1, 2'b01, 0, r);
        @(negedge clk);
        chk("R5 other node write", ctl_out, 2);
        send_word(5'd23, 0, 0, 2'b00, 0, r);
        chk("R5 other node read no pull", r, 7);
        send_word(5'd23, 1, 0, 2'b00, 0, r);
        send_word(5'd24, 0, 0, 2'b00, 0, r);
        chk("R5 other node parity no fault", r, live_reply(2'b00));
    endtask

    task automatic t_fault_apar;
        logic [2:0] r;
        stat_in = 2'b00;
        send_word(5'd24, 1, 0, 2'b00, 0, r);
        chk("R8 bad address parity read", r, 7);
        send_word(5'd24, 0, 1, 2'b01, 0, r);
        @(negedge clk);
        chk("R9 write blocked by fault", ctl_out, 2);
        send_word(5'd24, 1, 0, 2'b00, 0, r);
        chk("R8 fault read all ones", r, 7);
        send_word(5'd24, 0, 0, 2'b00, 0, r);
        chk("R10 clearing read still all ones", r, 7);
        send_word(5'd24, 0, 0, 2'b00, 0, r);
        chk("R10 live status after clear", r, live_reply(2'b00));
        send_word(5'd24, 0, 1, 2'b01, 0, r);
        @(negedge clk);
        chk("R10 write works after clear", ctl_out, 1);
    endtask

    task automatic t_fault_dpar;
        logic [2:0] r;
        stat_in = 2'b10;
        send_word(5'd24, 0, 1, 2'b10, 1, r);
        @(negedge clk);
        chk("R7 bad data parity no update", ctl_out, 1);
        send_word(5'd24, 0, 0, 2'b00, 0, r);
        chk("R7 data parity fault reply", r, 7);
        send_word(5'd24, 0, 0, 2'b00, 0, r);
        chk("R10 status after clear", r, live_reply(2'b10));
    endtask

    initial begin
        t_reset();
        t_sync();
        t_read();
        t_mismatch();
        t_fault_apar();
        t_fault_dpar();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule